// File: doc/BRIEF.md
# CAN Controller Mode and Mailbox Front End

This block is the register-side front end of a CAN controller. Software programs it through a simple word-addressed write port with a combinational read-back. It holds an enable control, a mode selector, a status view of the active mode, an interrupt status word with write-one-to-clear, a single transmit mailbox and a single receive mailbox. Bit-level framing, bit timing, arbitration and error handling sit outside this block. The CAN bus is seen here as a whole-frame port: a valid/ready output for frames leaving the node and a valid-only input for frames seen on the bus.

The mode is picked while the core is disabled and takes effect when the core is enabled. In normal mode a completed transmit mailbox is offered on the bus port. Loopback turns the frame back into the node's own receive mailbox. Snoop listens without ever transmitting. Sleep also refuses to transmit, and it returns to normal by itself when a frame arrives from the bus. Frames taken from the bus get a timestamp increment added to their length word. Looped-back frames are stored exactly as they were written.

Top module: `can_mbox_front`

## Requirements
- R1: After reset the core is disabled. The status word (0x18), the interrupt status word (0x1C) and all mailbox words read 0, and `btx_valid_o` is low.
- R2: Bit 1 of the word at 0x00 enables the core when written as 1 and disables it when written as 0. While the core is disabled, the status word reads 0 and a write to TX DATA2 (0x3C) starts no transfer. A frame on the bus input is dropped, leaving the RX mailbox unchanged and raising no interrupt.
- R3: The mode word at 0x04 selects normal with 0x00, sleep with 0x01, loopback with 0x02 and snoop with 0x04. While the core is enabled, the status word is one-hot: bit 3 for normal, bit 1 for loopback, bit 2 for sleep and bit 12 for snoop.
- R4: A mode written while the core is enabled reads back at 0x04 at once, but the active mode and the status word stay unchanged until the core has been disabled and enabled again.
- R5: In normal mode a write to TX DATA2 raises `btx_valid_o`, with `btx_frame_o` = {DATA2, DATA1, DLC, ID} (ID in bits 31:0). Valid and frame hold until `btx_ready_i` is seen high at a clock edge. That handshake drops valid and sets interrupt status bit 1. Writes to the TX words are ignored while a frame is pending.
- R6: In loopback mode a TX DATA2 write copies the four TX words unchanged into the RX mailbox (0x50 to 0x5C) and sets interrupt status bits 1 and 4. The bus port is not driven, and bus input frames are ignored.
- R7: In normal or snoop mode a bus frame is stored in the RX mailbox with its DLC word increased by TS_INC (default 1), and it sets interrupt status bit 4.
- R8: In sleep mode a bus frame switches the active mode to normal, so the status word reads 0x8. The frame is stored as in R7 and sets bit 4.
- R9: In snoop or sleep mode a TX DATA2 write never raises `btx_valid_o` and never sets interrupt status bit 1.
- R10: Writing 1 to a bit of the word at 0x24 clears that interrupt status bit. An event that sets the same bit in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| btx_valid_o | output | 1 | Frame offered to the bus |
| btx_ready_i | input | 1 | Bus accepts the offered frame |
| btx_frame_o | output | 128 | Outgoing frame {DATA2, DATA1, DLC, ID} |
| brx_valid_i | input | 1 | Frame present on the bus input |
| brx_frame_i | input | 128 | Incoming frame {DATA2, DATA1, DLC, ID} |

## Verification
The hardest cases to reach from the ports are the collision between a transmit handshake and a write to the interrupt-clear word in the same edge, and a mode change made while the core is enabled. For the collision, the bench first leaves a normal-mode frame pending with ready held low. It then raises ready in the same cycle as the clear write and checks that bit 1 is still set. For the held mode, it writes loopback during normal operation and sends a bus frame, which must still be stored with the timestamp added. Only after a disable and enable pair may the status word move to loopback. The sleep wake is reached by entering sleep and then presenting a bus frame. The status word is read right after that edge.

// File: rtl/can_mbox_pkg.sv
package can_mbox_pkg;
  localparam int WORD_W = 32;

  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_MODE  = 8'h04;
  localparam logic [7:0] A_STAT  = 8'h18;
  localparam logic [7:0] A_ISR   = 8'h1C;
  localparam logic [7:0] A_ICLR  = 8'h24;
  localparam logic [7:0] A_TX0   = 8'h30;
  localparam logic [7:0] A_RX0   = 8'h50;

  localparam int EN_BIT   = 1;
  localparam int TXOK_BIT = 1;
  localparam int RXOK_BIT = 4;

  typedef enum logic [1:0] {M_NORMAL, M_SLEEP, M_LOOP, M_SNOOP} mode_e;

  typedef struct packed {
    logic [WORD_W-1:0] d2;
    logic [WORD_W-1:0] d1;
    logic [WORD_W-1:0] dlc;
    logic [WORD_W-1:0] id;
  } frame_t;

  function automatic mode_e decode_mode(logic [2:0] m);
    if (m[1])      return M_LOOP;
    else if (m[2]) return M_SNOOP;
    else if (m[0]) return M_SLEEP;
    else           return M_NORMAL;
  endfunction

  function automatic logic [WORD_W-1:0] stat_bits(mode_e m);
    logic [WORD_W-1:0] s;
    s = '0;
    case (m)
      M_NORMAL: s[3]  = 1'b1;
      M_LOOP:   s[1]  = 1'b1;
      M_SLEEP:  s[2]  = 1'b1;
      default:  s[12] = 1'b1;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/can_mode_ctl.sv
module can_mode_ctl
  import can_mbox_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_wr_i,
  input  logic       ctrl_en_i,
  input  logic       mode_wr_i,
  input  logic [2:0] mode_wdata_i,
  input  logic       wake_i,
  output logic       en_o,
  output logic [2:0] mode_sel_o,
  output mode_e      act_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      mode_sel_o <= '0;
      act_o      <= M_NORMAL;
    end else begin
      if (mode_wr_i) mode_sel_o <= mode_wdata_i;
      if (ctrl_wr_i) begin
        en_o <= ctrl_en_i;
        // mode latches only on the disabled -> enabled step
        if (ctrl_en_i && !en_o) act_o <= decode_mode(mode_sel_o);
      end else if (wake_i) begin
        act_o <= M_NORMAL;
      end
    end
  end
endmodule

// File: rtl/can_irq_regs.sv
module can_irq_regs
  import can_mbox_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_done_i,
  input  logic              rx_done_i,
  input  logic              clr_wr_i,
  input  logic [WORD_W-1:0] clr_mask_i,
  output logic [WORD_W-1:0] isr_o
);
  localparam logic [WORD_W-1:0] IMPL = (WORD_W'(1) << TXOK_BIT) | (WORD_W'(1) << RXOK_BIT);

  logic [WORD_W-1:0] set_v, clr_v;

  always_comb begin
    set_v = '0;
    set_v[TXOK_BIT] = tx_done_i;
    set_v[RXOK_BIT] = rx_done_i;
    clr_v = clr_wr_i ? clr_mask_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_o <= '0;
    else         isr_o <= ((isr_o & ~clr_v) | set_v) & IMPL;
  end
endmodule

// File: rtl/can_mbox_path.sv
module can_mbox_path
  import can_mbox_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TS_INC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  mode_e             act_i,
  input  logic              drop_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              btx_ready_i,
  input  logic              brx_valid_i,
  input  frame_t            brx_frame_i,
  output logic              btx_valid_o,
  output frame_t            tx_o,
  output frame_t            rx_o,
  output logic              tx_done_o,
  output logic              rx_done_o
);
  localparam int NWORDS = 4;

  logic [NWORDS-1:0] tx_sel;
  logic              tx_open, go, loop_go, bus_go, hs, bus_rx;

  for (genvar g = 0; g < NWORDS; g++) begin : g_sel
    assign tx_sel[g] = wr_i && tx_open && (addr_i == ADDR_W'(A_TX0) + ADDR_W'(4 * g));
  end

  assign tx_open = !btx_valid_o;
  assign go      = tx_sel[NWORDS-1] && en_i;
  assign loop_go = go && (act_i == M_LOOP);
  assign bus_go  = go && (act_i == M_NORMAL);
  assign hs      = btx_valid_o && btx_ready_i;
  assign bus_rx  = brx_valid_i && en_i && (act_i != M_LOOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_o        <= '0;
      rx_o        <= '0;
      btx_valid_o <= 1'b0;
    end else begin
      if (tx_sel[0]) tx_o.id  <= wdata_i;
      if (tx_sel[1]) tx_o.dlc <= wdata_i;
      if (tx_sel[2]) tx_o.d1  <= wdata_i;
      if (tx_sel[3]) tx_o.d2  <= wdata_i;

      if (drop_i || hs) btx_valid_o <= 1'b0;
      else if (bus_go)  btx_valid_o <= 1'b1;

      if (loop_go) begin
        rx_o <= '{d2: wdata_i, d1: tx_o.d1, dlc: tx_o.dlc, id: tx_o.id};
      end else if (bus_rx) begin
        rx_o     <= brx_frame_i;
        rx_o.dlc <= brx_frame_i.dlc + WORD_W'(TS_INC);
      end
    end
  end

  assign tx_done_o = (hs && !drop_i) || loop_go;
  assign rx_done_o = loop_go || bus_rx;
endmodule

// File: rtl/can_mbox_front.sv
module can_mbox_front
  import can_mbox_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TS_INC = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [WORD_W-1:0]   reg_wdata_i,
  output logic [WORD_W-1:0]   reg_rdata_o,
  output logic                btx_valid_o,
  input  logic                btx_ready_i,
  output logic [4*WORD_W-1:0] btx_frame_o,
  input  logic                brx_valid_i,
  input  logic [4*WORD_W-1:0] brx_frame_i
);
  logic              en_q, ctrl_wr, mode_wr, clr_wr, wake, drop, tx_done, rx_done;
  logic [2:0]        mode_sel;
  mode_e             act;
  frame_t            tx_f, rx_f;
  logic [WORD_W-1:0] isr_q;

  assign ctrl_wr = reg_wr_i && (reg_addr_i == ADDR_W'(A_CTRL));
  assign mode_wr = reg_wr_i && (reg_addr_i == ADDR_W'(A_MODE));
  assign clr_wr  = reg_wr_i && (reg_addr_i == ADDR_W'(A_ICLR));
  assign drop    = ctrl_wr && !reg_wdata_i[EN_BIT];
  assign wake    = en_q && (act == M_SLEEP) && brx_valid_i;

  can_mode_ctl u_mode (
    .clk_i, .rst_ni,
    .ctrl_wr_i   (ctrl_wr),
    .ctrl_en_i   (reg_wdata_i[EN_BIT]),
    .mode_wr_i   (mode_wr),
    .mode_wdata_i(reg_wdata_i[2:0]),
    .wake_i      (wake),
    .en_o        (en_q),
    .mode_sel_o  (mode_sel),
    .act_o       (act)
  );

  can_mbox_path #(.ADDR_W(ADDR_W), .TS_INC(TS_INC)) u_path (
    .clk_i, .rst_ni,
    .en_i        (en_q),
    .act_i       (act),
    .drop_i      (drop),
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .btx_ready_i,
    .brx_valid_i,
    .brx_frame_i (frame_t'(brx_frame_i)),
    .btx_valid_o,
    .tx_o        (tx_f),
    .rx_o        (rx_f),
    .tx_done_o   (tx_done),
    .rx_done_o   (rx_done)
  );

  can_irq_regs u_irq (
    .clk_i, .rst_ni,
    .tx_done_i (tx_done),
    .rx_done_i (rx_done),
    .clr_wr_i  (clr_wr),
    .clr_mask_i(reg_wdata_i),
    .isr_o     (isr_q)
  );

  assign btx_frame_o = tx_f;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_W'(A_CTRL):      reg_rdata_o[EN_BIT] = en_q;
      ADDR_W'(A_MODE):      reg_rdata_o[2:0] = mode_sel;
      ADDR_W'(A_STAT):      reg_rdata_o = en_q ? stat_bits(act) : '0;
      ADDR_W'(A_ISR):       reg_rdata_o = isr_q;
      ADDR_W'(A_TX0):       reg_rdata_o = tx_f.id;
      ADDR_W'(A_TX0 + 4):   reg_rdata_o = tx_f.dlc;
      ADDR_W'(A_TX0 + 8):   reg_rdata_o = tx_f.d1;
      ADDR_W'(A_TX0 + 12):  reg_rdata_o = tx_f.d2;
      ADDR_W'(A_RX0):       reg_rdata_o = rx_f.id;
      ADDR_W'(A_RX0 + 4):   reg_rdata_o = rx_f.dlc;
      ADDR_W'(A_RX0 + 8):   reg_rdata_o = rx_f.d1;
      ADDR_W'(A_RX0 + 12):  reg_rdata_o = rx_f.d2;
      default:              reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/can_mbox_front_chk.sv
module can_mbox_front_chk
  import can_mbox_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                reg_wr_i,
  input logic [ADDR_W-1:0]   reg_addr_i,
  input logic [WORD_W-1:0]   reg_wdata_i,
  input logic [WORD_W-1:0]   reg_rdata_o,
  input logic                btx_valid_o,
  input logic                btx_ready_i,
  input logic [4*WORD_W-1:0] btx_frame_o,
  input logic                en_q,
  input logic [WORD_W-1:0]   isr_q
);
  logic dis_wr, stat_rd;
  assign dis_wr  = reg_wr_i && (reg_addr_i == ADDR_W'(A_CTRL)) && !reg_wdata_i[EN_BIT];
  assign stat_rd = (reg_addr_i == ADDR_W'(A_STAT));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (!btx_valid_o && isr_q == '0);
    end
  end

  assert_off_status_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && stat_rd) |-> (reg_rdata_o == '0));

  assert_stat_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |-> $onehot0(reg_rdata_o));

  assert_valid_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (btx_valid_o && !btx_ready_i && !dis_wr) |=> btx_valid_o);

  assert_frame_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (btx_valid_o && !btx_ready_i && !dis_wr) |=> $stable(btx_frame_o));

  assert_snoop_silent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && reg_rdata_o[12]) |-> !btx_valid_o);

  assert_w1c_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_W'(A_ICLR) && reg_wdata_i[TXOK_BIT] &&
     !(btx_valid_o && btx_ready_i)) |=> !isr_q[TXOK_BIT]);
endmodule

bind can_mbox_front can_mbox_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
  .btx_valid_o, .btx_ready_i, .btx_frame_o,
  .en_q (en_q),
  .isr_q(isr_q)
);

// File: tb/can_mbox_front_tb.sv
`timescale 1ns/1ps
module can_mbox_front_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [7:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         btx_valid;
  logic         btx_ready = 1'b0;
  logic [127:0] btx_frame;
  logic         brx_valid = 1'b0;
  logic [127:0] brx_frame = '0;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  can_mbox_front u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .btx_valid_o(btx_valid), .btx_ready_i(btx_ready), .btx_frame_o(btx_frame),
    .brx_valid_i(brx_valid), .brx_frame_i(brx_frame)
  );

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, {96'd0, v}, {96'd0, exp});
  endtask

  task automatic bus_in(input logic [127:0] f);
    @(negedge clk);
    brx_valid = 1'b1; brx_frame = f;
    @(negedge clk);
    brx_valid = 1'b0;
  endtask

  task automatic set_mode(input logic [31:0] m);
    wr(8'h00, 32'h0);
    wr(8'h04, m);
    wr(8'h00, 32'h2);
  endtask

  task automatic load_tx(input logic [31:0] id, input logic [31:0] dlc,
                         input logic [31:0] d1, input logic [31:0] d2);
    wr(8'h30, id); wr(8'h34, dlc); wr(8'h38, d1); wr(8'h3C, d2);
  endtask

  // {write, addr, data_or_expected}
  localparam int NV = 15;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'h0},
    {1'b1, 8'h04, 32'h2},
    {1'b1, 8'h00, 32'h2},
    {1'b0, 8'h18, 32'h2},
    {1'b1, 8'h30, 32'hFF},
    {1'b1, 8'h34, 32'h8000_0000},
    {1'b1, 8'h38, 32'h1234_5678},
    {1'b1, 8'h3C, 32'h8765_4321},
    {1'b0, 8'h1C, 32'h12},
    {1'b0, 8'h50, 32'hFF},
    {1'b0, 8'h54, 32'h8000_0000},
    {1'b0, 8'h58, 32'h1234_5678},
    {1'b0, 8'h5C, 32'h8765_4321},
    {1'b1, 8'h24, 32'h12},
    {1'b0, 8'h1C, 32'h0}
  };

  localparam logic [127:0] FRM = {32'h8765_4321, 32'h1234_5678, 32'h8000_0000, 32'h14};

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rchk("R1 status", 8'h18, 32'h0);
    rchk("R1 isr", 8'h1C, 32'h0);
    rchk("R1 rx id", 8'h50, 32'h0);
    chk("R1 btx_valid", {127'd0, btx_valid}, 128'd0);

    // R2 disabled: transmit and bus input ignored
    load_tx(32'h14, 32'h8000_0000, 32'h1234_5678, 32'h8765_4321);
    chk("R2 no tx when disabled", {127'd0, btx_valid}, 128'd0);
    bus_in(FRM);
    rchk("R2 isr when disabled", 8'h1C, 32'h0);
    rchk("R2 rx unchanged", 8'h54, 32'h0);

    // R6 loopback table (also R3 status bit 1)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) wr(VEC[i][39:32], VEC[i][31:0]);
      else rchk("R6 table", VEC[i][39:32], VEC[i][31:0]);
    end
    bus_in({32'h1, 32'h2, 32'h3, 32'h4});
    rchk("R6 bus ignored isr", 8'h1C, 32'h0);
    rchk("R6 bus ignored rx", 8'h50, 32'hFF);

    // R3 normal, R5 transmit with back-pressure
    set_mode(32'h0);
    rchk("R3 normal status", 8'h18, 32'h8);
    rchk("R2 enable readback", 8'h00, 32'h2);
    load_tx(32'h14, 32'h8000_0000, 32'h1234_5678, 32'h8765_4321);
    chk("R5 valid raised", {127'd0, btx_valid}, 128'd1);
    chk("R5 frame", btx_frame, FRM);
    wr(8'h30, 32'hDEAD);
    repeat (3) @(negedge clk);
    chk("R5 valid held", {127'd0, btx_valid}, 128'd1);
    chk("R5 frame held", btx_frame, FRM);
    rchk("R5 no txok before ready", 8'h1C, 32'h0);
    btx_ready = 1'b1;
    @(negedge clk);
    btx_ready = 1'b0;
    chk("R5 valid dropped", {127'd0, btx_valid}, 128'd0);
    rchk("R5 txok", 8'h1C, 32'h2);
    wr(8'h24, 32'h2);
    rchk("R10 clear", 8'h1C, 32'h0);

    // R10 set wins over clear
    load_tx(32'h21, 32'h4, 32'h5, 32'h6);
    @(negedge clk);
    btx_ready = 1'b1; reg_wr = 1'b1; reg_addr = 8'h24; reg_wdata = 32'h2;
    @(negedge clk);
    btx_ready = 1'b0; reg_wr = 1'b0;
    rchk("R10 set wins", 8'h1C, 32'h2);
    wr(8'h24, 32'h12);

    // R4 mode held while enabled; R7 normal receive
    wr(8'h04, 32'h2);
    rchk("R4 mode readback", 8'h04, 32'h2);
    rchk("R4 status held", 8'h18, 32'h8);
    bus_in(FRM);
    rchk("R7 normal rxok", 8'h1C, 32'h10);
    rchk("R7 dlc timestamp", 8'h54, 32'h8000_0001);
    rchk("R7 id", 8'h50, 32'h14);
    wr(8'h24, 32'h10);
    wr(8'h00, 32'h0);
    wr(8'h00, 32'h2);
    rchk("R4 applied on re-enable", 8'h18, 32'h2);

    // R3/R9/R7 snoop
    set_mode(32'h4);
    rchk("R3 snoop status", 8'h18, 32'h1000);
    load_tx(32'h33, 32'h1, 32'h2, 32'h3);
    chk("R9 snoop no bus", {127'd0, btx_valid}, 128'd0);
    rchk("R9 snoop no txok", 8'h1C, 32'h0);
    bus_in({32'hA, 32'hB, 32'h7, 32'h55});
    rchk("R7 snoop rxok", 8'h1C, 32'h10);
    rchk("R7 snoop dlc", 8'h54, 32'h8);
    wr(8'h24, 32'h10);

    // R3/R9/R8 sleep and wake
    set_mode(32'h1);
    rchk("R3 sleep status", 8'h18, 32'h4);
    load_tx(32'h44, 32'h1, 32'h2, 32'h3);
    chk("R9 sleep no bus", {127'd0, btx_valid}, 128'd0);
    rchk("R9 sleep no txok", 8'h1C, 32'h0);
    bus_in(FRM);
    rchk("R8 woke to normal", 8'h18, 32'h8);
    rchk("R8 rxok", 8'h1C, 32'h10);
    rchk("R8 dlc timestamp", 8'h54, 32'h8000_0001);
    rchk("R8 data2", 8'h5C, 32'h8765_4321);

    // R2 disable drops the status view
    wr(8'h00, 32'h0);
    rchk("R2 status zero when disabled", 8'h18, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule